// File: doc/BRIEF.md
# Controller status word and dual interrupt unit

This block keeps the status word of a card host controller. The command and data engines report events through one-cycle set pulses. Each pulse latches a sticky bit, and the bit stays set until software clears it by writing ones to a write-one-to-clear register. Alongside the sticky events, the word carries a command-busy flag and ten FIFO-level flags. These are driven live by the data engine and appear in the word without being stored.

Two interrupt lines each have their own 32-bit mask. A line is high whenever the status word ANDed with its mask is nonzero. The same 32-bit register bus holds the small configuration registers for power, card clock, transfer length and data control, each trimmed to its implemented width. The top of the 4 KiB window returns eight read-only identification bytes, one byte per word.

Top module: `sts_irq_top`

## Requirements
- R1: After reset every register, mask and sticky bit reads zero and both interrupt lines are low.
- R2: A set pulse on evt_set_i bit b (b in 0..10, except 9) makes status bit b read one from the next cycle on. The bit stays one until it is cleared.
- R3: A write to offset 0x38 clears each status bit in 10:0 whose written bit is one. Written zeros, and written bits above 10, change nothing.
- R4: When a set pulse and a clear of the same bit fall in the same cycle, the set wins and the bit reads one afterwards.
- R5: Status bit 11 equals cmd_busy_i and bits 21:12 equal fifo_flags_i[9:0] in the same cycle, with no storage. Bits 31:22 read zero. Bit 9 is reserved: it never latches and always reads zero.
- R6: Mask 0 is at 0x3C and mask 1 is at 0x40. Both hold and read back all 32 bits. irq_o[k] is one exactly when (status AND mask k) is nonzero, so it follows a mask write or a status change in the cycle that register updates, and follows the live bits at once.
- R7: Reads at 0xFE0, 0xFE4, …, 0xFFC return 0x81, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that address order, with bits 31:8 zero. Writes there have no effect.
- R8: Power (0x00), clock (0x04) and data control (0x2C) keep the low 8 bits of a write. Data length (0x28) keeps the low 16 bits. Each value drives its output port and reads back.
- R9: Reads of any other offset, of the clear register, and of any address with bits 1:0 nonzero return zero. Writes to such offsets, and to the status offset 0x34, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Byte address within the register window |
| we_i | input | 1 | Write enable for the current cycle |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| evt_set_i | input | 11 | One-cycle set pulses for sticky bits 10:0 |
| cmd_busy_i | input | 1 | Live command-busy flag (status bit 11) |
| fifo_flags_i | input | 10 | Live FIFO-level flags (status bits 21:12) |
| irq_o | output | 2 | Interrupt lines 0 and 1 |
| pwr_o | output | 8 | Power register |
| clk_cfg_o | output | 8 | Card clock register |
| dlen_o | output | 16 | Data length register |
| dctl_o | output | 8 | Data control register |

## Verification
Register writes and set pulses are captured at a clock edge. Their effect on rdata_o and irq_o is therefore due one cycle later, and the bench samples after the following falling edge. The live status bits and the read mux are combinational, so those checks are taken 2 ns after the falling edge on which the inputs or the address were driven. A driver task queues each expected value at the moment it drives the stimulus. A monitor compares the queued values at the fixed sample point, so every comparison lands in the cycle where the result is due.

// File: rtl/sts_pkg.sv
package sts_pkg;
  localparam int DW      = 32;
  localparam int AW      = 12;
  localparam int EVT_W   = 11;
  localparam int FIFO_W  = 10;
  localparam int NUM_IRQ = 2;
  localparam logic [EVT_W-1:0] EVT_USED = 11'h5FF;  // bit 9 reserved

  localparam logic [AW-1:0] OFF_PWR   = 12'h000;
  localparam logic [AW-1:0] OFF_CLK   = 12'h004;
  localparam logic [AW-1:0] OFF_DLEN  = 12'h028;
  localparam logic [AW-1:0] OFF_DCTL  = 12'h02C;
  localparam logic [AW-1:0] OFF_STAT  = 12'h034;
  localparam logic [AW-1:0] OFF_CLR   = 12'h038;
  localparam logic [AW-1:0] OFF_MASK0 = 12'h03C;
  localparam logic [AW-1:0] OFF_ID    = 12'hFE0;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0: id_byte = 8'h81;
      3'd1: id_byte = 8'h11;
      3'd2: id_byte = 8'h04;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/sts_evt_reg.sv
module sts_evt_reg #(
  parameter int N = 11,
  parameter logic [N-1:0] USED = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] evt_o
);
  logic [N-1:0] evt_q;

  // set beats clear so a same-cycle event survives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= '0;
    else         evt_q <= ((evt_q & ~clr_i) | set_i) & USED;
  end
  assign evt_o = evt_q;

  for (genvar b = 0; b < N; b++) begin : g_chk
    if (USED[b]) begin : g_used
      assert_set_latches_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i[b] |=> evt_q[b]);
      assert_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i[b] && !set_i[b]) |=> !evt_q[b]);
      assert_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_q[b] && !clr_i[b]) |=> evt_q[b]);
      assert_set_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_i[b] && clr_i[b]) |=> evt_q[b]);
    end else begin : g_rsvd
      assert_reserved_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !evt_q[b]);
    end
  end
endmodule

// File: rtl/sts_irq_mask.sv
module sts_irq_mask #(
  parameter int DW = 32,
  parameter int NUM_IRQ = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_IRQ-1:0]     we_i,
  input  logic [DW-1:0]          wdata_i,
  input  logic [DW-1:0]          status_i,
  output logic [NUM_IRQ*DW-1:0]  mask_o,
  output logic [NUM_IRQ-1:0]     irq_o
);
  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_line
    logic [DW-1:0] mask_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   mask_q <= '0;
      else if (we_i[k]) mask_q <= wdata_i;
    end
    assign mask_o[k*DW +: DW] = mask_q;
    assign irq_o[k] = |(status_i & mask_q);

    assert_mask_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i[k] |=> mask_q == $past(wdata_i));
    assert_masked_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mask_q == '0) |-> !irq_o[k]);
  end
endmodule

// File: rtl/sts_cfg_regs.sv
module sts_cfg_regs (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_pwr_i,
  input  logic        we_clk_i,
  input  logic        we_dlen_i,
  input  logic        we_dctl_i,
  input  logic [15:0] wdata_i,
  output logic [7:0]  pwr_o,
  output logic [7:0]  clk_cfg_o,
  output logic [15:0] dlen_o,
  output logic [7:0]  dctl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_o <= '0; clk_cfg_o <= '0; dlen_o <= '0; dctl_o <= '0;
    end else begin
      if (we_pwr_i)  pwr_o     <= wdata_i[7:0];
      if (we_clk_i)  clk_cfg_o <= wdata_i[7:0];
      if (we_dlen_i) dlen_o    <= wdata_i;
      if (we_dctl_i) dctl_o    <= wdata_i[7:0];
    end
  end

  assert_pwr_trim_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_pwr_i |=> pwr_o == $past(wdata_i[7:0]));
  assert_dlen_trim_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_dlen_i |=> dlen_o == $past(wdata_i));
  assert_dctl_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_dctl_i |=> $stable(dctl_o));
endmodule

// File: rtl/sts_irq_top.sv
module sts_irq_top
  import sts_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [AW-1:0]       addr_i,
  input  logic                we_i,
  input  logic [DW-1:0]       wdata_i,
  output logic [DW-1:0]       rdata_o,
  input  logic [EVT_W-1:0]    evt_set_i,
  input  logic                cmd_busy_i,
  input  logic [FIFO_W-1:0]   fifo_flags_i,
  output logic [NUM_IRQ-1:0]  irq_o,
  output logic [7:0]          pwr_o,
  output logic [7:0]          clk_cfg_o,
  output logic [15:0]         dlen_o,
  output logic [7:0]          dctl_o
);
  localparam int PAD_W = DW - EVT_W - 1 - FIFO_W;

  logic aligned, id_hit;
  logic [EVT_W-1:0] evt, clr;
  logic [DW-1:0] status;
  logic [NUM_IRQ*DW-1:0] masks;
  logic [NUM_IRQ-1:0] we_mask;

  assign aligned = addr_i[1:0] == 2'b00;
  assign id_hit  = aligned && addr_i >= OFF_ID;
  assign clr     = (we_i && addr_i == OFF_CLR) ? wdata_i[EVT_W-1:0] : '0;

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_we
    assign we_mask[k] = we_i && addr_i == OFF_MASK0 + AW'(4*k);
  end

  sts_evt_reg #(.N(EVT_W), .USED(EVT_USED)) u_evt (
    .clk_i, .rst_ni, .set_i(evt_set_i), .clr_i(clr), .evt_o(evt)
  );

  assign status = {{PAD_W{1'b0}}, fifo_flags_i, cmd_busy_i, evt};

  sts_irq_mask #(.DW(DW), .NUM_IRQ(NUM_IRQ)) u_mask (
    .clk_i, .rst_ni, .we_i(we_mask), .wdata_i, .status_i(status),
    .mask_o(masks), .irq_o
  );

  sts_cfg_regs u_cfg (
    .clk_i, .rst_ni,
    .we_pwr_i (we_i && addr_i == OFF_PWR),
    .we_clk_i (we_i && addr_i == OFF_CLK),
    .we_dlen_i(we_i && addr_i == OFF_DLEN),
    .we_dctl_i(we_i && addr_i == OFF_DCTL),
    .wdata_i  (wdata_i[15:0]),
    .pwr_o, .clk_cfg_o, .dlen_o, .dctl_o
  );

  always_comb begin
    rdata_o = '0;
    if (id_hit) begin
      rdata_o = {24'b0, id_byte(addr_i[4:2])};
    end else begin
      case (addr_i)
        OFF_PWR:  rdata_o = {24'b0, pwr_o};
        OFF_CLK:  rdata_o = {24'b0, clk_cfg_o};
        OFF_DLEN: rdata_o = {16'b0, dlen_o};
        OFF_DCTL: rdata_o = {24'b0, dctl_o};
        OFF_STAT: rdata_o = status;
        default: begin
          for (int k = 0; k < NUM_IRQ; k++)
            if (addr_i == OFF_MASK0 + AW'(4*k)) rdata_o = masks[k*DW +: DW];
        end
      endcase
    end
  end

  assert_id_byte_wide_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_hit |-> rdata_o[DW-1:8] == '0);
  assert_misaligned_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !aligned |-> rdata_o == '0);
  assert_clear_reads_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == OFF_CLR |-> rdata_o == '0);
  assert_irq_low_no_status_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status == '0 |-> irq_o == '0);
endmodule

// File: tb/sim_sts_irq_top.sv
module sim_sts_irq_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [10:0] evt_set = '0;
  logic busy = 1'b0;
  logic [9:0] fifo = '0;
  logic [1:0] irq;
  logic [7:0] pwr, clkc, dctl;
  logic [15:0] dlen;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sts_irq_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .evt_set_i(evt_set), .cmd_busy_i(busy),
    .fifo_flags_i(fifo), .irq_o(irq), .pwr_o(pwr), .clk_cfg_o(clkc),
    .dlen_o(dlen), .dctl_o(dctl)
  );

  typedef struct {
    int          sel;   // 0 rdata, 1 irq, 2 output ports packed
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  // monitor: compare 2 ns after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        case (it.sel)
          0: act = rdata;
          1: act = {30'b0, irq};
          default: act = {pwr, clkc, dctl, dlen[7:0]};
        endcase
        n_run++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic chk_rd(input logic [11:0] a, input logic [31:0] e, input string t);
    @(negedge clk); addr = a;
    q.push_back('{0, e, t});
  endtask

  task automatic chk_irq(input logic [1:0] e, input string t);
    @(negedge clk);
    q.push_back('{1, {30'b0, e}, t});
  endtask

  task automatic pulse(input logic [10:0] b);
    @(negedge clk); evt_set = b;
    @(negedge clk); evt_set = '0;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk_rd(12'h034, 32'h0, "R1 status");
    chk_rd(12'h000, 32'h0, "R1 power");
    chk_rd(12'h03C, 32'h0, "R1 mask0");
    chk_rd(12'h040, 32'h0, "R1 mask1");
    chk_irq(2'b00, "R1 irq");
    // R8 trimmed config registers
    wr(12'h000, 32'h0000_ABCD); chk_rd(12'h000, 32'h0000_00CD, "R8 power");
    wr(12'h004, 32'h1234_5678); chk_rd(12'h004, 32'h0000_0078, "R8 clock");
    wr(12'h028, 32'hDEAD_BEEF); chk_rd(12'h028, 32'h0000_BEEF, "R8 dlen");
    wr(12'h02C, 32'h0000_01FF); chk_rd(12'h02C, 32'h0000_00FF, "R8 dctl");
    @(negedge clk); q.push_back('{2, {8'hCD, 8'h78, 8'hFF, 8'hEF}, "R8 ports"});
    // R2 set pulses
    pulse(11'h045); chk_rd(12'h034, 32'h0000_0045, "R2 latch");
    repeat (3) @(negedge clk);
    chk_rd(12'h034, 32'h0000_0045, "R2 sticky");
    // R5 reserved bit 9
    pulse(11'h200); chk_rd(12'h034, 32'h0000_0045, "R5 bit9");
    // R3 clear with upper bits ignored
    wr(12'h038, 32'hFFFF_F004); chk_rd(12'h034, 32'h0000_0041, "R3 partial");
    // R5 live bits
    @(negedge clk); busy = 1'b1; fifo = 10'h2AA;
    chk_rd(12'h034, 32'h002A_A841, "R5 live");
    wr(12'h038, 32'hFFFF_FFFF); chk_rd(12'h034, 32'h002A_A800, "R3 full clear");
    @(negedge clk); busy = 1'b0; fifo = '0;
    chk_rd(12'h034, 32'h0, "R5 live off");
    // R4 set and clear same cycle
    @(negedge clk); evt_set = 11'h100; addr = 12'h038; we = 1'b1; wdata = 32'h100;
    @(negedge clk); evt_set = '0; we = 1'b0;
    chk_rd(12'h034, 32'h0000_0100, "R4 set wins");
    // R6 interrupts
    wr(12'h03C, 32'h0000_0100); chk_irq(2'b01, "R6 line0");
    wr(12'h040, 32'h0010_0000); chk_irq(2'b01, "R6 line1 masked");
    chk_rd(12'h040, 32'h0010_0000, "R6 mask1 read");
    @(negedge clk); fifo = 10'h100;
    q.push_back('{1, 32'h3, "R6 live irq"});
    wr(12'h038, 32'h0000_0100); chk_irq(2'b10, "R6 after clear");
    @(negedge clk); fifo = '0;
    q.push_back('{1, 32'h0, "R6 both low"});
    // R7 identification bytes
    for (int i = 0; i < 8; i++) begin
      logic [7:0] e;
      case (i)
        0: e = 8'h81; 1: e = 8'h11; 2: e = 8'h04; 3: e = 8'h00;
        4: e = 8'h0D; 5: e = 8'hF0; 6: e = 8'h05; default: e = 8'hB1;
      endcase
      chk_rd(12'hFE0 + 12'(4*i), {24'b0, e}, "R7 id");
    end
    wr(12'hFE0, 32'hFFFF_FFFF); chk_rd(12'hFE0, 32'h81, "R7 id write");
    // R9 unmapped and read-only
    wr(12'h044, 32'hFFFF_FFFF); chk_rd(12'h044, 32'h0, "R9 unmapped");
    chk_rd(12'h038, 32'h0, "R9 clear reads zero");
    chk_rd(12'h03D, 32'h0, "R9 misaligned");
    wr(12'h034, 32'h0000_FFFF); chk_rd(12'h034, 32'h0, "R9 status write");
    chk_rd(12'h000, 32'h0000_00CD, "R9 power kept");
    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule